// File: doc/BRIEF.md
# Double-Buffered Digital Crosspoint Switch

This block routes a bus of single-bit data lanes. It has `NPORT` inputs and `NPORT` outputs and is fully non-blocking. Each output takes its value from at most one input, and one input can feed any number of outputs. The connection map is written over a synchronous configuration port. That port has an active-low enable, a 4-bit opcode, an output selector and an input selector. Writes go into a staging copy of the map, and a single `commit` strobe moves the whole staged map into the live map in one clock. Many route changes therefore appear on the outputs together. The data path is combinational from `data_in` through per-output multiplexers steered by the live map.

A flood command temporarily drives one chosen input onto every output. The live map is kept untouched underneath it. The next `commit` leaves flood mode and brings back exactly the routes that were live before. A wipe command clears both copies of the map. A probe command reports whether a given output currently carries a given input, through a registered status bit.

The mode controller has two states. In `MODE_ROUTE` the live map drives the outputs. In `MODE_FLOOD` the flood source drives every output. Its transitions are:
- route-to-flood, on a flood command;
- flood-to-flood, when a new flood command retargets the source;
- flood-to-route on commit, which restores the live map;
- flood-to-route on wipe.

A wipe in `MODE_ROUTE` and an idle cycle in either state keep the state.

Top module: `xbar_crosspoint`

## Requirements
- R1: After reset, every output is unconnected and drives 0, `probe_bit` is 0, and the mode is `MODE_ROUTE`.
- R2: The configuration port is sampled at a rising clock edge only while `cfg_en_n` is 0. The opcodes are 4'h1 link, 4'h2 unlink, 4'h3 probe, 4'h4 flood and 4'h5 wipe. Any other opcode, or any opcode while `cfg_en_n` is 1, has no effect on outputs, map or `probe_bit`.
- R3: Link (output `cfg_out_sel` takes input `cfg_in_sel`) and unlink (output `cfg_out_sel` disconnected) change only the staged map. The outputs do not change until a commit.
- R4: `commit` high at an edge in `MODE_ROUTE` copies the whole staged map, as it stood before that edge, into the live map. The outputs follow the new map from that edge on. Routes whose entry is not changed keep passing data on every cycle.
- R5: Linking an output that is already linked replaces its old input in that single command, with no unlink needed.
- R6: A linked output equals `data_in` at its input index. Several outputs may share one input. An unlinked output drives 0.
- R7: From the edge that accepts a flood command, every output equals `data_in[cfg_in_sel]` as sampled at that edge. The live map is left unchanged.
- R8: `commit` in `MODE_FLOOD` returns to `MODE_ROUTE` and restores the pre-flood routes without copying the staged map. Staged writes made during flood take effect at the following commit.
- R9: Wipe clears the staged and live maps to all-unconnected and leaves flood mode, effective from the accepting edge.
- R10: Probe sets `probe_bit` after the accepting edge. The bit is 1 only when output `cfg_out_sel` is currently carrying input `cfg_in_sel`: either flood from that input, or a live link to it. Otherwise the bit is 0. The bit holds until the next probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_n | input | 1 | Active-low configuration enable |
| cfg_op | input | 4 | Configuration opcode |
| cfg_out_sel | input | AW | Output index for link, unlink and probe |
| cfg_in_sel | input | AW | Input index for link, probe and flood |
| commit | input | 1 | Global update strobe |
| data_in | input | NPORT | Input lanes |
| data_out | output | NPORT | Output lanes |
| probe_bit | output | 1 | Registered connection status |

## Verification
The routing function is driven with fresh random lane data on every cycle, so a wrong multiplexer choice shows up as a mismatch against the reference model. Four patterns are applied:
- Fan-out patterns, with several outputs on one input and corner indices 0 and NPORT-1, tell correct index decoding apart from aliasing between neighbouring entries.
- Staged writes checked before and after commit tell double buffering apart from write-through.
- A relink without unlink, and a flood followed by commit, check that replacement and restoration keep the old live routes intact.
- A long random mix of opcodes, enables and commits, including illegal opcodes and commits in the same cycle as writes, exercises the edge ordering between staging, copying and mode changes.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Configuration opcodes
    localparam logic [3:0] OP_LINK   = 4'h1;
    localparam logic [3:0] OP_UNLINK = 4'h2;
    localparam logic [3:0] OP_PROBE  = 4'h3;
    localparam logic [3:0] OP_FLOOD  = 4'h4;
    localparam logic [3:0] OP_WIPE   = 4'h5;

    typedef enum logic {
        MODE_ROUTE = 1'b0,
        MODE_FLOOD = 1'b1
    } mode_e;

endpackage

// File: rtl/xbar_cmd_decode.sv
module xbar_cmd_decode
    import xbar_pkg::*;
(
    input  logic       cfg_en_n,
    input  logic [3:0] cfg_op,
    output logic       cmd_link,
    output logic       cmd_unlink,
    output logic       cmd_probe,
    output logic       cmd_flood,
    output logic       cmd_wipe
);

    always_comb begin
        cmd_link   = 1'b0;
        cmd_unlink = 1'b0;
        cmd_probe  = 1'b0;
        cmd_flood  = 1'b0;
        cmd_wipe   = 1'b0;
        if (!cfg_en_n) begin
            unique case (cfg_op)
                OP_LINK:   cmd_link   = 1'b1;
                OP_UNLINK: cmd_unlink = 1'b1;
                OP_PROBE:  cmd_probe  = 1'b1;
                OP_FLOOD:  cmd_flood  = 1'b1;
                OP_WIPE:   cmd_wipe   = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xbar_mode_fsm.sv
module xbar_mode_fsm
    import xbar_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_flood,
    input  logic          cmd_wipe,
    input  logic          commit,
    input  logic [AW-1:0] src_in,
    output logic          flood_on,
    output logic [AW-1:0] flood_src,
    output logic          copy_en
);

    mode_e          state_q, state_d;
    logic [AW-1:0]  src_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_ROUTE;
            src_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_flood) src_q <= src_in;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_ROUTE: begin
                if (cmd_flood) state_d = MODE_FLOOD;
            end
            MODE_FLOOD: begin
                if (cmd_wipe)       state_d = MODE_ROUTE;
                else if (cmd_flood) state_d = MODE_FLOOD;
                else if (commit)    state_d = MODE_ROUTE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        flood_on  = (state_q == MODE_FLOOD);
        flood_src = src_q;
        copy_en   = commit && !cmd_wipe && (state_q == MODE_ROUTE);
    end

    AST_FLOOD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_flood |=> (flood_on && flood_src == $past(src_in)));   // R7
    AST_FLOOD_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (flood_on && commit && !cmd_flood) |=> !flood_on);         // R8
    AST_WIPE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wipe |=> !flood_on);                                    // R9

endmodule

// File: rtl/xbar_cfg_store.sv
module xbar_cfg_store #(
    parameter int NPORT = 128,
    parameter int AW    = 7,
    localparam int EW   = AW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_link,
    input  logic                      cmd_unlink,
    input  logic                      cmd_probe,
    input  logic                      cmd_wipe,
    input  logic                      copy_en,
    input  logic [AW-1:0]             out_sel,
    input  logic [AW-1:0]             in_sel,
    input  logic                      flood_on,
    input  logic [AW-1:0]             flood_src,
    output logic [NPORT-1:0][EW-1:0]  active_q,
    output logic                      probe_q
);

    // Entry layout: bit AW = valid, bits AW-1:0 = input index
    logic [NPORT-1:0][EW-1:0] shadow_q;
    logic                     sel_ok;
    logic                     hit;

    assign sel_ok = (int'(out_sel) < NPORT);
    assign hit    = flood_on ? (in_sel == flood_src)
                             : (sel_ok && active_q[out_sel][AW] &&
                                active_q[out_sel][AW-1:0] == in_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
            shadow_q <= '0;
            probe_q  <= 1'b0;
        end else begin
            if (cmd_wipe) begin
                active_q <= '0;
                shadow_q <= '0;
            end else begin
                if (copy_en) active_q <= shadow_q;
                if (cmd_link && sel_ok)
                    shadow_q[out_sel] <= {1'b1, in_sel};
                else if (cmd_unlink && sel_ok)
                    shadow_q[out_sel] <= '0;
            end
            if (cmd_probe) probe_q <= hit;
        end
    end

    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!copy_en && !cmd_wipe) |=> $stable(active_q));            // R3
    AST_COPY_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_en && !cmd_wipe) |=> (active_q == $past(shadow_q))); // R4
    AST_WIPE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wipe |=> (active_q == '0 && shadow_q == '0));           // R9
    AST_PROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_probe |=> $stable(probe_q));                           // R10
    AST_NO_COPY_FLOOD: assert property (@(posedge clk) disable iff (!rst_n)
        flood_on |-> !copy_en);                                     // R8

endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
    parameter int NPORT = 128,
    parameter int AW    = 7,
    localparam int EW   = AW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          data_in,
    input  logic [NPORT-1:0][EW-1:0]  active,
    input  logic                      flood_on,
    input  logic [AW-1:0]             flood_src,
    output logic [NPORT-1:0]          data_out
);

    for (genvar o = 0; o < NPORT; o++) begin : g_lane
        always_comb begin
            if (flood_on)
                data_out[o] = data_in[flood_src];
            else if (active[o][AW])
                data_out[o] = data_in[active[o][AW-1:0]];
            else
                data_out[o] = 1'b0;
        end

        AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!flood_on && !active[o][AW]) |-> !data_out[o]);        // R6
    end

endmodule

// File: rtl/xbar_crosspoint.sv
module xbar_crosspoint
    import xbar_pkg::*;
#(
    parameter int NPORT = 128,
    localparam int AW   = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int EW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en_n,
    input  logic [3:0]       cfg_op,
    input  logic [AW-1:0]    cfg_out_sel,
    input  logic [AW-1:0]    cfg_in_sel,
    input  logic             commit,
    input  logic [NPORT-1:0] data_in,
    output logic [NPORT-1:0] data_out,
    output logic             probe_bit
);

    logic                     cmd_link, cmd_unlink, cmd_probe, cmd_flood, cmd_wipe;
    logic                     flood_on, copy_en;
    logic [AW-1:0]            flood_src;
    logic [NPORT-1:0][EW-1:0] active;

    xbar_cmd_decode u_decode (
        .cfg_en_n   (cfg_en_n),
        .cfg_op     (cfg_op),
        .cmd_link   (cmd_link),
        .cmd_unlink (cmd_unlink),
        .cmd_probe  (cmd_probe),
        .cmd_flood  (cmd_flood),
        .cmd_wipe   (cmd_wipe)
    );

    xbar_mode_fsm #(.AW(AW)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_flood (cmd_flood),
        .cmd_wipe  (cmd_wipe),
        .commit    (commit),
        .src_in    (cfg_in_sel),
        .flood_on  (flood_on),
        .flood_src (flood_src),
        .copy_en   (copy_en)
    );

    xbar_cfg_store #(.NPORT(NPORT), .AW(AW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_link   (cmd_link),
        .cmd_unlink (cmd_unlink),
        .cmd_probe  (cmd_probe),
        .cmd_wipe   (cmd_wipe),
        .copy_en    (copy_en),
        .out_sel    (cfg_out_sel),
        .in_sel     (cfg_in_sel),
        .flood_on   (flood_on),
        .flood_src  (flood_src),
        .active_q   (active),
        .probe_q    (probe_bit)
    );

    xbar_route #(.NPORT(NPORT), .AW(AW)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .active    (active),
        .flood_on  (flood_on),
        .flood_src (flood_src),
        .data_out  (data_out)
    );

    AST_IGNORED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en_n && !commit) |=> ($stable(active) && $stable(probe_bit))); // R2

endmodule

// File: tb/xbar_crosspoint_bench.sv
`timescale 1ns/1ps
module xbar_crosspoint_bench;

    localparam int N  = 128;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en_n = 1'b1;
    logic [3:0]    cfg_op = 4'h0;
    logic [AW-1:0] osel = '0;
    logic [AW-1:0] isel = '0;
    logic          commit = 1'b0;
    logic [N-1:0]  din = '0;
    logic [N-1:0]  dout;
    logic          pbit;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    // Behavioural reference: -1 means unconnected
    int m_sh[N];
    int m_act[N];
    bit m_fl = 0;
    int m_src = 0;
    bit m_pb = 0;

    always #2.5 clk = ~clk;

    xbar_crosspoint #(.NPORT(N)) u_xbar_crosspoint (
        .clk(clk), .rst_n(rst_n), .cfg_en_n(cfg_en_n), .cfg_op(cfg_op),
        .cfg_out_sel(osel), .cfg_in_sel(isel), .commit(commit),
        .data_in(din), .data_out(dout), .probe_bit(pbit)
    );

    function automatic logic [N-1:0] expect_out();
        logic [N-1:0] e;
        for (int o = 0; o < N; o++) begin
            if (m_fl)            e[o] = din[m_src];
            else if (m_act[o] >= 0) e[o] = din[m_act[o]];
            else                 e[o] = 1'b0;
        end
        return e;
    endfunction

    task automatic compare_all();
        logic [N-1:0] e;
        e = expect_out();
        checks++;
        if (dout !== e) begin
            errors++;
            $display("FAIL %s data_out actual %h expected %h", tag, dout, e);
        end
        checks++;
        if (pbit !== m_pb) begin
            errors++;
            $display("FAIL %s probe_bit actual %0b expected %0b", tag, pbit, m_pb);
        end
    endtask

    task automatic model_edge();
        bit en, clr, fl;
        int o, i;
        en  = !cfg_en_n;
        clr = en && cfg_op == 4'h5;
        fl  = en && cfg_op == 4'h4;
        o   = int'(osel);
        i   = int'(isel);
        if (en && cfg_op == 4'h3)
            m_pb = m_fl ? (i == m_src) : (m_act[o] == i);
        if (clr) begin
            for (int k = 0; k < N; k++) begin m_sh[k] = -1; m_act[k] = -1; end
            m_fl = 0;
        end else begin
            if (commit && !m_fl) m_act = m_sh;
            if (fl) begin m_fl = 1; m_src = i; end
            else if (commit) m_fl = 0;
            if (en && cfg_op == 4'h1) m_sh[o] = i;
            if (en && cfg_op == 4'h2) m_sh[o] = -1;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
        din = {$urandom, $urandom, $urandom, $urandom};
        #0.5;
        compare_all();
    endtask

    task automatic cmd(input logic [3:0] op, input int o, input int i, input bit cm);
        cfg_en_n = 1'b0; cfg_op = op; osel = AW'(o); isel = AW'(i); commit = cm;
        tick();
        cfg_en_n = 1'b1; cfg_op = 4'h0; commit = 1'b0;
    endtask

    task automatic do_commit();
        commit = 1'b1;
        tick();
        commit = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL R1 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) begin m_sh[k] = -1; m_act[k] = -1; end
        din = {$urandom, $urandom, $urandom, $urandom};
        repeat (3) @(posedge clk);
        #1;
        tag = "R1"; compare_all();           // reset state
        rst_n = 1'b1;
        idle(2);

        // R3: staged links, outputs still idle; R6 fan-out and corners
        tag = "R3";
        cmd(4'h1, 0, 5, 0);
        cmd(4'h1, 1, 5, 0);
        cmd(4'h1, 127, 127, 0);
        cmd(4'h1, 64, 0, 0);
        idle(2);
        tag = "R4"; do_commit();
        tag = "R6"; idle(4);

        // R5: relink without unlink
        tag = "R5";
        cmd(4'h1, 0, 9, 0);
        do_commit();
        idle(3);

        // R3 unlink staged then committed
        tag = "R3";
        cmd(4'h2, 1, 0, 0);
        idle(1);
        do_commit();

        // R2: disabled port and illegal opcodes ignored
        tag = "R2";
        cfg_op = 4'h5; osel = 0; isel = 0; cfg_en_n = 1'b1; tick(); cfg_op = 4'h0;
        cmd(4'hF, 0, 3, 0);
        cmd(4'h0, 127, 1, 0);
        do_commit();
        idle(2);

        // R10: probes
        tag = "R10";
        cmd(4'h3, 0, 9, 0);
        cmd(4'h3, 0, 5, 0);
        cmd(4'h3, 127, 127, 0);
        idle(3);
        cmd(4'h3, 2, 0, 0);

        // R7/R8: flood, staged write during flood, restore, then pending applied
        tag = "R7";
        cmd(4'h4, 0, 33, 0);
        idle(3);
        cmd(4'h1, 2, 77, 0);
        tag = "R10"; cmd(4'h3, 90, 33, 0);
        tag = "R8";
        do_commit();
        idle(2);
        cmd(4'h3, 2, 77, 0);
        do_commit();
        cmd(4'h3, 2, 77, 0);

        // R9: wipe from flood
        tag = "R9";
        cmd(4'h4, 0, 12, 0);
        cmd(4'h5, 0, 0, 0);
        idle(2);
        do_commit();

        // R4: random mix, including commit with writes
        tag = "R4";
        for (int n = 0; n < 2000; n++) begin
            int r;
            r = int'($urandom_range(0, 15));
            cfg_en_n = ($urandom_range(0, 3) == 0);
            cfg_op   = (r < 6) ? 4'h1 : (r < 8) ? 4'h2 : (r < 10) ? 4'h3 :
                       (r == 10) ? 4'h4 : (r == 11 && $urandom_range(0, 3) == 0) ? 4'h5 :
                       4'($urandom_range(6, 15));
            osel     = AW'($urandom);
            isel     = AW'($urandom);
            commit   = ($urandom_range(0, 4) == 0);
            tick();
        end
        cfg_en_n = 1'b1; commit = 1'b0;
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule